// File: doc/BRIEF.md
# Threshold-Interrupt Event FIFO

This block holds up to 32 sixteen-bit event words that a host pushes in and a sequencer pulls out in arrival order. The host side and the consumer side are both valid/ready streams. A write is taken on a cycle where `in_valid` and `in_ready` are both high. `in_ready` is high whenever a slot is free. A word offered while the buffer is full is not taken and is lost, and a sticky `overflow` flag records the loss. On the consumer side the head word is presented first-word-fall-through. It is offered only while the `run` control is high, and it leaves the buffer on a cycle where `out_valid` and `out_ready` are both high.

An active-low, level-sensitive request `irq_n` asks the host for more words. It is low while the enable input is 1 and the number of stored words is at or below a 5-bit threshold. The host drops the enable, tops the buffer up past the threshold, and then raises the enable again. Lowering `run` discards every stored word. A software clear discards every stored word and also clears the overflow flag. The stored word count is brought out for observation.

Top module: `evt_fifo_irq`

## Requirements
- R1: Words leave in the order they were accepted. `out_data` shows the oldest stored word at full 16-bit width, and `out_valid` is 1 exactly when `run` is 1 and the count is above zero.
- R2: The capacity is 32 words. `in_ready` is 1 exactly when the count is below 32. Each accepted write with no pop raises `level` by one after the next rising edge.
- R3: A write offered while `in_ready` is 0 is dropped and leaves the stored words unchanged. `overflow` becomes 1 after that edge and stays 1 until a software clear.
- R4: `out_ready` while `out_valid` is 0 removes nothing, and the count stays at zero when the buffer is empty.
- R5: An accepted write and an accepted pop on the same edge leave `level` unchanged.
- R6: `irq_n` is 0 exactly when `irq_en` is 1 and `level` is less than or equal to `irq_thresh`, where `irq_thresh` is a value from 0 (empty) to 31 (one free slot). `irq_n` follows changes of `level`, `irq_en` or `irq_thresh` in the same cycle.
- R7: On the first edge at which `run` is sampled 0 after having been 1, the buffer is emptied. A write offered in that cycle is discarded, and `overflow` is left as it was.
- R8: `soft_clr` sampled 1 empties the buffer and clears `overflow` at that edge.
- R9: After reset, `level` is 0, `overflow` is 0, `in_ready` is 1 and `out_valid` is 0.
- R10: While `run` is 0, `out_valid` is 0 and `out_ready` removes nothing, but writes are still accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| soft_clr | input | 1 | Software clear: empties the buffer and clears overflow |
| run | input | 1 | Playback enable; a fall from 1 to 0 empties the buffer |
| in_valid | input | 1 | Host offers a word |
| in_data | input | 16 | Host word |
| in_ready | output | 1 | A slot is free |
| out_valid | output | 1 | Head word is offered to the consumer |
| out_data | output | 16 | Oldest stored word |
| out_ready | input | 1 | Consumer takes the head word |
| irq_thresh | input | 5 | Request threshold, 0 to 31 |
| irq_en | input | 1 | Request enable |
| irq_n | output | 1 | Refill request, active low |
| level | output | 6 | Number of stored words, 0 to 32 |
| overflow | output | 1 | Sticky flag for a dropped write |

## Verification
`level`, `in_ready`, `overflow` and the buffer contents change one rising edge after the handshake, flush or clear that causes the change. The outputs `out_valid`, `out_data` and `irq_n` are combinational from that registered state and from the current inputs, so they are due in the same cycle. The bench drives every input on the falling edge and checks the registered results 1 ns after the following rising edge. It sweeps the threshold and the enable in short sub-cycle steps while the registered state is held, so every combination is checked against the level in force at that moment.

// File: rtl/evt_fifo_pkg.sv
package evt_fifo_pkg;
  localparam int unsigned WORD_W      = 16;
  localparam int unsigned SLOTS       = 32;
  localparam int unsigned THRESH_W    = 5;
  localparam int unsigned PTR_W       = $clog2(SLOTS);
  localparam int unsigned CNT_W       = PTR_W + 1;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [CNT_W-1:0]  count_t;
endpackage

// File: rtl/evt_fifo_store.sv
module evt_fifo_store #(
  parameter int unsigned DW    = 16,
  parameter int unsigned DEPTH = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       flush,
  input  logic                       push,
  input  logic [DW-1:0]              wdata,
  input  logic                       pop,
  output logic [DW-1:0]              rdata,
  output logic [$clog2(DEPTH):0]     count
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned CW = AW + 1;

  logic [DW-1:0] slot_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] count_q;

  // one write-enabled register per slot
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (push && (wr_ptr_q == AW'(g)))
        slot_q[g] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else if (flush) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (push) wr_ptr_q <= wr_ptr_q + AW'(1);
      if (pop)  rd_ptr_q <= rd_ptr_q + AW'(1);
      unique case ({push, pop})
        2'b10:   count_q <= count_q + CW'(1);
        2'b01:   count_q <= count_q - CW'(1);
        default: count_q <= count_q;
      endcase
    end
  end

  assign rdata = slot_q[rd_ptr_q];
  assign count = count_q;
endmodule

// File: rtl/evt_fifo_flush_ctl.sv
module evt_fifo_flush_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic soft_clr,
  input  logic run,
  input  logic drop_attempt,
  output logic flush,
  output logic overflow
);
  logic run_q;
  logic ovf_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      run_q <= run;
      if (soft_clr)          ovf_q <= 1'b0;
      else if (drop_attempt) ovf_q <= 1'b1;
    end
  end

  // stop edge or software clear empties the buffer on this edge
  assign flush    = soft_clr | (run_q & ~run);
  assign overflow = ovf_q;
endmodule

// File: rtl/evt_fifo_irq_gen.sv
module evt_fifo_irq_gen #(
  parameter int unsigned CW = 6,
  parameter int unsigned TW = 5
) (
  input  logic [CW-1:0] level,
  input  logic [TW-1:0] thresh,
  input  logic          enable,
  output logic          irq_n
);
  logic [CW-1:0] thresh_ext;
  logic          at_or_below;

  if (CW > TW) begin : g_widen
    assign thresh_ext = {{(CW-TW){1'b0}}, thresh};
  end else begin : g_same
    assign thresh_ext = CW'(thresh);
  end

  assign at_or_below = (level <= thresh_ext);
  assign irq_n       = ~(enable & at_or_below);
endmodule

// File: rtl/evt_fifo_irq.sv
module evt_fifo_irq
  import evt_fifo_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                soft_clr,
  input  logic                run,
  input  logic                in_valid,
  input  logic [WORD_W-1:0]   in_data,
  output logic                in_ready,
  output logic                out_valid,
  output logic [WORD_W-1:0]   out_data,
  input  logic                out_ready,
  input  logic [THRESH_W-1:0] irq_thresh,
  input  logic                irq_en,
  output logic                irq_n,
  output logic [CNT_W-1:0]    level,
  output logic                overflow
);
  logic   flush;
  logic   push, pop;
  count_t count;

  assign in_ready  = (count != CNT_W'(SLOTS));
  assign out_valid = run & (count != '0);
  assign push      = in_valid & in_ready & ~flush;
  assign pop       = out_valid & out_ready & ~flush;
  assign level     = count;

  evt_fifo_flush_ctl u_flush (
    .clk          (clk),
    .rst_n        (rst_n),
    .soft_clr     (soft_clr),
    .run          (run),
    .drop_attempt (in_valid & ~in_ready),
    .flush        (flush),
    .overflow     (overflow)
  );

  evt_fifo_store #(.DW(WORD_W), .DEPTH(SLOTS)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (flush),
    .push  (push),
    .wdata (in_data),
    .pop   (pop),
    .rdata (out_data),
    .count (count)
  );

  evt_fifo_irq_gen #(.CW(CNT_W), .TW(THRESH_W)) u_irq (
    .level  (count),
    .thresh (irq_thresh),
    .enable (irq_en),
    .irq_n  (irq_n)
  );
endmodule

// File: rtl/evt_fifo_chk.sv
module evt_fifo_chk
  import evt_fifo_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                soft_clr,
  input logic                run,
  input logic                in_valid,
  input logic [WORD_W-1:0]   in_data,
  input logic                in_ready,
  input logic                out_valid,
  input logic [WORD_W-1:0]   out_data,
  input logic                out_ready,
  input logic [THRESH_W-1:0] irq_thresh,
  input logic                irq_en,
  input logic                irq_n,
  input logic [CNT_W-1:0]    level,
  input logic                overflow
);
  logic seen_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_run <= 1'b0;
    else        seen_run <= run;
  end

  // R2
  level_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level <= CNT_W'(SLOTS));

  // R3
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !soft_clr) |=> overflow);

  // R4
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (level == '0 && out_ready && !in_valid) |=> (level == '0));

  // R5
  both_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && out_valid && out_ready && !soft_clr && run) |=> $stable(level));

  // R6
  irq_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en && ({1'b0, irq_thresh} >= level)) |-> !irq_n);

  // R6
  irq_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_en) |-> irq_n);

  // R7
  stop_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_run && !run) |=> (level == '0));

  // R8
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_clr |=> (level == '0 && !overflow));

  // R10
  idle_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !out_valid);
endmodule

bind evt_fifo_irq evt_fifo_chk chk_i (.*);

// File: tb/evt_fifo_irq_tb.sv
`timescale 1ns/1ps
module evt_fifo_irq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        soft_clr = 1'b0;
  logic        run = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] in_data = '0;
  logic        in_ready;
  logic        out_valid;
  logic [15:0] out_data;
  logic        out_ready = 1'b0;
  logic [4:0]  irq_thresh = '0;
  logic        irq_en = 1'b1;
  logic        irq_n;
  logic [5:0]  level;
  logic        overflow;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [15:0] mq[$];
  bit prev_run = 0;
  bit exp_ovf = 0;

  always #2 clk = ~clk;

  evt_fifo_irq dut_i (.*);

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(bit wv, logic [15:0] wd, bit rd, bit rn, bit clr);
    bit flush, acc_w, acc_p;
    @(negedge clk);
    in_valid = wv; in_data = wd; out_ready = rd; run = rn; soft_clr = clr;
    #1;
    check("R1 out_valid", int'(out_valid), int'(rn && mq.size() > 0));
    if (rn && mq.size() > 0) check("R1 out_data", int'(out_data), int'(mq[0]));
    flush = clr || (prev_run && !rn);
    acc_w = wv && mq.size() < 32 && !flush;
    acc_p = rd && rn && mq.size() > 0 && !flush;
    if (clr) exp_ovf = 0;
    else if (wv && mq.size() == 32) exp_ovf = 1;
    @(posedge clk);
    #1;
    if (flush) mq.delete();
    else begin
      if (acc_p) void'(mq.pop_front());
      if (acc_w) mq.push_back(wd);
    end
    prev_run = rn;
    in_valid = 0; out_ready = 0; soft_clr = 0;
    check("R2 level", int'(level), mq.size());
    check("R2 in_ready", int'(in_ready), int'(mq.size() < 32));
    check("R3 overflow", int'(overflow), int'(exp_ovf));
  endtask

  task automatic irq_sweep();
    for (int en = 0; en < 2; en++) begin
      for (int th = 0; th < 32; th++) begin
        irq_en = en[0]; irq_thresh = th[4:0];
        #0.05;
        check("R6 irq_n", int'(irq_n), int'(!(en == 1 && mq.size() <= th)));
      end
    end
    irq_en = 1'b1; irq_thresh = 5'd4;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R9 reset state
    check("R9 level", int'(level), 0);
    check("R9 overflow", int'(overflow), 0);
    check("R9 in_ready", int'(in_ready), 1);
    check("R9 out_valid", int'(out_valid), 0);
    irq_sweep();

    // R2 R3 R6 fill past capacity while stopped
    for (int i = 0; i < 34; i++) begin
      step(1, 16'(i * 613 + 7), 0, 0, 0);
      irq_sweep();
    end
    // R10 pop while stopped is ignored
    step(0, 16'h0, 1, 0, 0);
    check("R10 level kept", int'(level), 32);

    // R1 drain half in order
    step(0, 16'h0, 0, 1, 0);
    for (int i = 0; i < 16; i++) begin
      step(0, 16'h0, 1, 1, 0);
      irq_sweep();
    end
    // R5 simultaneous write and pop
    for (int i = 0; i < 4; i++) begin
      step(1, 16'hC000 + 16'(i), 1, 1, 0);
      check("R5 level", int'(level), 16);
    end
    // R1 drain rest, then R4 pops on empty
    for (int i = 0; i < 18; i++) begin
      step(0, 16'h0, 1, 1, 0);
      irq_sweep();
    end
    check("R4 empty level", int'(level), 0);
    check("R4 out_valid", int'(out_valid), 0);

    // R7 stop empties; write in stop cycle discarded
    for (int i = 0; i < 5; i++) step(1, 16'h5A00 + 16'(i), 0, 1, 0);
    step(1, 16'hDEAD, 0, 0, 0);
    check("R7 flushed", int'(level), 0);
    check("R7 overflow kept", int'(overflow), 1);
    for (int i = 0; i < 3; i++) step(1, 16'h7700 + 16'(i), 0, 0, 0);
    check("R10 write while stopped", int'(level), 3);

    // R8 software clear
    step(0, 16'h0, 0, 0, 1);
    check("R8 level", int'(level), 0);
    check("R8 overflow", int'(overflow), 0);
    step(1, 16'h1234, 0, 1, 0);
    step(0, 16'h0, 1, 1, 0);
    check("R1 after clear", int'(level), 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule